// File: doc/BRIEF.md
# Trace Cache with Fill Unit

This block pairs a small direct-mapped trace cache with the fill unit that builds its lines. The fill unit watches the stream of retired instructions. It gathers them, in retirement order, into a pending trace that begins at the address of its first instruction. When the trace is complete, the fill unit writes it into the cache as one line. A line holds the instruction words in order, a direction flag for each branch inside the trace, a marker that says whether the last instruction is a branch, and two successor addresses: one for when that final branch falls through and one for when it is taken.

The front end looks the cache up with a fetch address and a vector of predicted branch directions. A hit returns the whole trace and the address to fetch next, one cycle after the request. A miss returns hit=0, and the front end then falls back to its ordinary instruction fetch path. Lines are direct mapped. A new trace whose start address has the same index overwrites the line already there.

Top module: `trace_cache`

## Requirements
- R1: While reset is asserted, resp_valid and resp_hit are 0. Reset leaves every line invalid, so a lookup made before any line has been filled misses.
- R2: With fewer than 3 branches collected, a trace closes when its 8th instruction retires, and the line then holds 8 instructions.
- R3: A trace closes when its 3rd branch retires, even with fewer than 8 instructions collected. Whichever limit is reached first ends the trace.
- R4: A lookup hits when the line is valid, its tag matches, and fetch_pred[i] equals the stored direction of the i-th branch of the trace (bit 0 is the first branch in retirement order, 1 means taken) for every i below the line's branch count. Prediction bits at or above the branch count are ignored.
- R5: On a hit where the last instruction is a branch, resp_next_pc is that branch's target if the branch was taken, and the branch's PC + 4 if it was not.
- R6: On a hit where the last instruction is not a branch, resp_next_pc is the PC of the last instruction + 4.
- R7: The lookup response appears in the cycle after fetch_valid is sampled. A line is written at the clock edge after the edge at which its trace closes. A lookup sampled at that write edge still misses, and one sampled at the next edge hits.
- R8: Writing a line to an occupied index replaces the old line. The old start address then misses and the new one hits.
- R9: On a hit, resp_count gives the number of instructions, and resp_instrs holds them in retirement order, with slot k at bits [32k+31:32k] and unused slots zero. On a miss, resp_count, resp_next_pc and resp_instrs are all zero.
- R10: The line index is start PC bits [5:2] and the tag is bits [31:6]. PC bits [1:0] play no part in the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | A retired instruction is presented this cycle |
| ret_pc | input | 32 | Address of the retired instruction |
| ret_instr | input | 32 | Retired instruction word |
| ret_is_br | input | 1 | The retired instruction is a conditional branch |
| ret_taken | input | 1 | The branch was taken |
| ret_target | input | 32 | Branch target address |
| fetch_valid | input | 1 | Lookup request |
| fetch_pc | input | 32 | Lookup address |
| fetch_pred | input | 3 | Predicted directions, bit 0 for the first branch |
| resp_valid | output | 1 | Response to the request of the previous cycle |
| resp_hit | output | 1 | The lookup hit |
| resp_count | output | 4 | Number of instructions in the returned trace |
| resp_next_pc | output | 32 | Next fetch address after the trace |
| resp_instrs | output | 256 | Trace instruction words, slot 0 in the low bits |

## Verification
Each lookup result is due one cycle after its request. A filled line becomes visible two edges after the edge at which its closing instruction retires. The bench's behavioural model uses the same rule: at every rising edge it computes the expected response from its line table before it applies the write left pending from the previous edge, and only then handles the new retirement. The DUT outputs are compared with these expectations at the following falling edge. The directed cases check the close edge, the write edge and the edge after it, sampling each one at the falling edge that follows.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int TC_PCW   = 32;
  localparam int TC_IW    = 32;
  localparam int TC_N     = 8;
  localparam int TC_M     = 3;
  localparam int TC_LINES = 16;

  localparam int CNT_W  = $clog2(TC_N + 1);
  localparam int SLOT_W = $clog2(TC_N);
  localparam int BR_W   = $clog2(TC_M + 1);
  localparam int IDX_W  = $clog2(TC_LINES);
  localparam int TAG_W  = TC_PCW - 2 - IDX_W;

  typedef struct packed {
    logic [TAG_W-1:0]             tag;
    logic [CNT_W-1:0]             cnt;
    logic [BR_W-1:0]              nbr;
    logic [TC_M-1:0]              flags;
    logic                         last_br;
    logic [TC_PCW-1:0]            fall;
    logic [TC_PCW-1:0]            tgt;
    logic [TC_N-1:0][TC_IW-1:0]   ins;
  } tc_line_t;

  function automatic logic [IDX_W-1:0] pc_index(input logic [TC_PCW-1:0] pc);
    return pc[2 +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] pc_tag(input logic [TC_PCW-1:0] pc);
    return pc[TC_PCW-1 -: TAG_W];
  endfunction

  // Compare only as many direction bits as the line embeds branches.
  function automatic logic dirs_match(input logic [TC_M-1:0] pred,
                                      input logic [TC_M-1:0] flags,
                                      input logic [BR_W-1:0] nbr);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < TC_M; i++) begin
      if (i < int'(nbr) && pred[i] != flags[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  // Successor of a line: the final branch's recorded direction picks the address.
  function automatic logic [TC_PCW-1:0] line_next(input tc_line_t l);
    logic tk;
    tk = 1'b0;
    for (int i = 0; i < TC_M; i++) begin
      if (i + 1 == int'(l.nbr)) tk = l.flags[i];
    end
    return (l.last_br && tk) ? l.tgt : l.fall;
  endfunction
endpackage

// File: rtl/tc_fill_unit.sv
module tc_fill_unit
  import tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic [TC_PCW-1:0] ret_pc,
  input  logic [TC_IW-1:0]  ret_instr,
  input  logic              ret_is_br,
  input  logic              ret_taken,
  input  logic [TC_PCW-1:0] ret_target,
  output logic              close_evt,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output tc_line_t          wr_line
);
  logic [CNT_W-1:0]           pend_cnt;
  logic [BR_W-1:0]            pend_br;
  logic [TC_PCW-1:0]          pend_start;
  logic [TC_N-1:0][TC_IW-1:0] pend_ins;
  logic [TC_M-1:0]            pend_flags;

  logic                       fresh;
  logic [CNT_W-1:0]           nxt_cnt;
  logic [BR_W-1:0]            nxt_br;
  logic [TC_PCW-1:0]          nxt_start;
  logic [TC_N-1:0][TC_IW-1:0] nxt_ins;
  logic [TC_M-1:0]            nxt_flags;

  always_comb begin
    fresh     = (pend_cnt == '0);
    nxt_ins   = fresh ? '0 : pend_ins;
    nxt_flags = fresh ? '0 : pend_flags;
    nxt_start = fresh ? ret_pc : pend_start;
    nxt_ins[pend_cnt[SLOT_W-1:0]] = ret_instr;
    if (ret_is_br) nxt_flags[pend_br] = ret_taken;
    nxt_cnt   = pend_cnt + CNT_W'(1);
    nxt_br    = pend_br + BR_W'(ret_is_br);
  end

  assign close_evt = ret_valid &&
                     (nxt_cnt == CNT_W'(TC_N) || nxt_br == BR_W'(TC_M));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_cnt   <= '0;
      pend_br    <= '0;
      pend_start <= '0;
      pend_ins   <= '0;
      pend_flags <= '0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_line    <= '0;
    end else begin
      wr_en <= close_evt;
      if (ret_valid) begin
        pend_ins   <= nxt_ins;
        pend_flags <= nxt_flags;
        pend_start <= nxt_start;
        if (close_evt) begin
          pend_cnt        <= '0;
          pend_br         <= '0;
          wr_idx          <= pc_index(nxt_start);
          wr_line.tag     <= pc_tag(nxt_start);
          wr_line.cnt     <= nxt_cnt;
          wr_line.nbr     <= nxt_br;
          wr_line.flags   <= nxt_flags;
          wr_line.last_br <= ret_is_br;
          wr_line.fall    <= ret_pc + TC_PCW'(4);
          wr_line.tgt     <= ret_is_br ? ret_target : ret_pc + TC_PCW'(4);
          wr_line.ins     <= nxt_ins;
        end else begin
          pend_cnt <= nxt_cnt;
          pend_br  <= nxt_br;
        end
      end
    end
  end

  AST_PEND_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt < CNT_W'(TC_N)); // R2
  AST_PEND_BR_BELOW_M: assert property (@(posedge clk) disable iff (!rst_n)
    pend_br < BR_W'(TC_M)); // R3
  AST_CLOSE_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> wr_en); // R7
  AST_WRITE_NEEDS_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    !close_evt |=> !wr_en); // R7
endmodule

// File: rtl/tc_line_store.sv
module tc_line_store
  import tc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  tc_line_t                    wr_line,
  input  logic                        fetch_valid,
  input  logic [TC_PCW-1:0]           fetch_pc,
  input  logic [TC_M-1:0]             fetch_pred,
  output logic                        lookup_hit,
  output logic                        resp_valid,
  output logic                        resp_hit,
  output logic [CNT_W-1:0]            resp_count,
  output logic [TC_PCW-1:0]           resp_next,
  output logic [TC_N-1:0][TC_IW-1:0]  resp_ins
);
  logic [TC_LINES-1:0] valid_w;
  tc_line_t            mem_w [TC_LINES];

  for (genvar g = 0; g < TC_LINES; g++) begin : g_line
    logic     v_q;
    tc_line_t l_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                v_q <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(g))     v_q <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) l_q <= wr_line;
    end
    assign valid_w[g] = v_q;
    assign mem_w[g]   = l_q;
  end

  logic [IDX_W-1:0] rd_idx;
  tc_line_t         rd_line;

  assign rd_idx     = pc_index(fetch_pc);
  assign rd_line    = mem_w[rd_idx];
  assign lookup_hit = fetch_valid && valid_w[rd_idx] &&
                      rd_line.tag == pc_tag(fetch_pc) &&
                      dirs_match(fetch_pred, rd_line.flags, rd_line.nbr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_count <= '0;
      resp_next  <= '0;
      resp_ins   <= '0;
    end else begin
      resp_valid <= fetch_valid;
      resp_hit   <= lookup_hit;
      resp_count <= lookup_hit ? rd_line.cnt : '0;
      resp_next  <= lookup_hit ? line_next(rd_line) : '0;
      resp_ins   <= lookup_hit ? rd_line.ins : '0;
    end
  end

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> resp_valid); // R7
  AST_HIT_NEEDS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> resp_valid); // R9
  AST_MISS_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_count == '0 && resp_next == '0)); // R9
  AST_INVALID_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !valid_w[rd_idx]) |=> !resp_hit); // R1
endmodule

// File: rtl/trace_cache.sv
module trace_cache
  import tc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ret_valid,
  input  logic [TC_PCW-1:0]        ret_pc,
  input  logic [TC_IW-1:0]         ret_instr,
  input  logic                     ret_is_br,
  input  logic                     ret_taken,
  input  logic [TC_PCW-1:0]        ret_target,
  input  logic                     fetch_valid,
  input  logic [TC_PCW-1:0]        fetch_pc,
  input  logic [TC_M-1:0]          fetch_pred,
  output logic                     resp_valid,
  output logic                     resp_hit,
  output logic [CNT_W-1:0]         resp_count,
  output logic [TC_PCW-1:0]        resp_next_pc,
  output logic [TC_N*TC_IW-1:0]    resp_instrs
);
  logic                       close_evt;
  logic                       wr_en;
  logic [IDX_W-1:0]           wr_idx;
  tc_line_t                   wr_line;
  logic                       lookup_hit;
  logic [TC_N-1:0][TC_IW-1:0] resp_ins;

  tc_fill_unit u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .ret_valid  (ret_valid),
    .ret_pc     (ret_pc),
    .ret_instr  (ret_instr),
    .ret_is_br  (ret_is_br),
    .ret_taken  (ret_taken),
    .ret_target (ret_target),
    .close_evt  (close_evt),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_line    (wr_line)
  );

  tc_line_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_line     (wr_line),
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .fetch_pred  (fetch_pred),
    .lookup_hit  (lookup_hit),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .resp_count  (resp_count),
    .resp_next   (resp_next_pc),
    .resp_ins    (resp_ins)
  );

  assign resp_instrs = resp_ins;

  AST_HIT_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> (resp_hit && resp_count != '0)); // R9
endmodule

// File: tb/trace_cache_tb.sv
module trace_cache_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ret_valid = 1'b0;
  logic [31:0]  ret_pc = '0;
  logic [31:0]  ret_instr = '0;
  logic         ret_is_br = 1'b0;
  logic         ret_taken = 1'b0;
  logic [31:0]  ret_target = '0;
  logic         fetch_valid = 1'b0;
  logic [31:0]  fetch_pc = '0;
  logic [2:0]   fetch_pred = '0;
  logic         resp_valid;
  logic         resp_hit;
  logic [3:0]   resp_count;
  logic [31:0]  resp_next_pc;
  logic [255:0] resp_instrs;

  trace_cache u_dut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_instr(ret_instr), .ret_is_br(ret_is_br), .ret_taken(ret_taken),
    .ret_target(ret_target), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_pred(fetch_pred), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_count(resp_count), .resp_next_pc(resp_next_pc), .resp_instrs(resp_instrs)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;
  bit run_cmp  = 0;

  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_valid [16];
  logic [31:0] m_start [16];
  int          m_cnt   [16];
  int          m_nbr   [16];
  bit          m_flag  [16][3];
  bit          m_lastbr[16];
  logic [31:0] m_next  [16];
  logic [31:0] m_ins   [16][8];

  logic [31:0] q_pc[$];
  logic [31:0] q_ins[$];
  bit          q_br[$];
  bit          q_tk[$];
  logic [31:0] q_tgt[$];

  bit          wp_v;
  int          wp_idx;
  logic [31:0] wp_start, wp_next;
  int          wp_cnt, wp_nbr;
  bit          wp_flag[3];
  bit          wp_lastbr;
  logic [31:0] wp_ins[8];

  logic         exp_rv, exp_hit, exp_lastbr;
  logic [3:0]   exp_cnt;
  logic [31:0]  exp_next;
  logic [255:0] exp_ins;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_valid[i]) m_valid[i] = 0;
      q_pc.delete(); q_ins.delete(); q_br.delete(); q_tk.delete(); q_tgt.delete();
      wp_v = 0;
      exp_rv = 0; exp_hit = 0; exp_lastbr = 0; exp_cnt = 0; exp_next = 0; exp_ins = 0;
    end else begin
      // response from the table as it stood before this edge
      exp_rv = fetch_valid; exp_hit = 0; exp_cnt = 0; exp_next = 0; exp_ins = 0;
      exp_lastbr = 0;
      if (fetch_valid) begin
        int ix;
        bit ok;
        ix = int'((fetch_pc >> 2) % 16);
        ok = m_valid[ix] && ((m_start[ix] >> 2) == (fetch_pc >> 2));
        for (int k = 0; k < m_nbr[ix]; k++) if (fetch_pred[k] != m_flag[ix][k]) ok = 0;
        if (ok) begin
          exp_hit = 1; exp_cnt = 4'(m_cnt[ix]); exp_next = m_next[ix];
          exp_lastbr = m_lastbr[ix];
          for (int s = 0; s < m_cnt[ix]; s++) exp_ins[s*32 +: 32] = m_ins[ix][s];
        end
      end
      if (wp_v) begin
        m_valid[wp_idx] = 1; m_start[wp_idx] = wp_start; m_cnt[wp_idx] = wp_cnt;
        m_nbr[wp_idx] = wp_nbr; m_lastbr[wp_idx] = wp_lastbr; m_next[wp_idx] = wp_next;
        for (int k = 0; k < 3; k++) m_flag[wp_idx][k] = wp_flag[k];
        for (int s = 0; s < 8; s++) m_ins[wp_idx][s] = wp_ins[s];
        wp_v = 0;
      end
      if (ret_valid) begin
        int nb;
        q_pc.push_back(ret_pc); q_ins.push_back(ret_instr); q_br.push_back(ret_is_br);
        q_tk.push_back(ret_taken); q_tgt.push_back(ret_target);
        nb = 0;
        foreach (q_br[j]) if (q_br[j]) nb++;
        if (q_pc.size() == 8 || nb == 3) begin
          int last, k;
          last = q_pc.size() - 1;
          wp_v = 1; wp_start = q_pc[0]; wp_idx = int'((q_pc[0] >> 2) % 16);
          wp_cnt = q_pc.size(); wp_nbr = nb; wp_lastbr = q_br[last];
          wp_next = (q_br[last] && q_tk[last]) ? q_tgt[last] : q_pc[last] + 4;
          for (int j = 0; j < 3; j++) wp_flag[j] = 0;
          for (int s = 0; s < 8; s++) wp_ins[s] = (s <= last) ? q_ins[s] : 32'h0;
          k = 0;
          foreach (q_br[j]) if (q_br[j]) begin wp_flag[k] = q_tk[j]; k++; end
          q_pc.delete(); q_ins.delete(); q_br.delete(); q_tk.delete(); q_tgt.delete();
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && run_cmp && !done) begin
      check("R7", "resp_valid", 256'(resp_valid), 256'(exp_rv));
      check("R4", "resp_hit", 256'(resp_hit), 256'(exp_hit));
      check(exp_lastbr ? "R5" : "R6", "resp_next_pc", 256'(resp_next_pc), 256'(exp_next));
      check("R9", "resp_count", 256'(resp_count), 256'(exp_cnt));
      check("R9", "resp_instrs", resp_instrs, exp_ins);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic retire_one(input logic [31:0] pc, input logic [31:0] ins,
                            input bit br, input bit tk, input logic [31:0] tgt);
    ret_valid = 1; ret_pc = pc; ret_instr = ins; ret_is_br = br;
    ret_taken = tk; ret_target = tgt;
    @(negedge clk);
    ret_valid = 0; ret_is_br = 0; ret_taken = 0;
  endtask

  task automatic do_fetch(input logic [31:0] pc, input logic [2:0] pred);
    fetch_valid = 1; fetch_pc = pc; fetch_pred = pred;
    @(negedge clk);
    fetch_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [31:0] rs = 32'h1ACE_B00C;
  function automatic logic [31:0] rnd_step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] cur_pc;
    idle(2);
    check("R1", "resp_valid in reset", 256'(resp_valid), 256'(0));
    check("R1", "resp_hit in reset", 256'(resp_hit), 256'(0));
    rst_n = 1;
    run_cmp = 1;
    do_fetch(32'h0000_0100, 3'b000);
    check("R1", "hit before fill", 256'(resp_hit), 256'(0));

    // Trace A: 8 straight-line instructions from 0x1000 (index 0)
    for (int i = 0; i < 7; i++) retire_one(32'h1000 + 32'(4*i), 32'hA000 + 32'(i), 0, 0, 0);
    ret_valid = 1; ret_pc = 32'h101C; ret_instr = 32'hA007; ret_is_br = 0;
    fetch_valid = 1; fetch_pc = 32'h1000; fetch_pred = 3'b000;
    @(negedge clk);
    ret_valid = 0;
    check("R7", "lookup at close edge", 256'(resp_hit), 256'(0));
    @(negedge clk);
    check("R7", "lookup at write edge", 256'(resp_hit), 256'(0));
    @(negedge clk);
    fetch_valid = 0;
    check("R7", "lookup after write edge", 256'(resp_hit), 256'(1));
    check("R2", "count at instruction limit", 256'(resp_count), 256'(8));
    check("R6", "next after straight line", 256'(resp_next_pc), 256'(32'h1020));
    check("R9", "slot 7 word", 256'(resp_instrs[255:224]), 256'(32'hA007));

    // Trace B: closes on its 3rd branch after 5 instructions (index 1)
    retire_one(32'h3004, 32'hB000, 0, 0, 0);
    retire_one(32'h3008, 32'hB001, 1, 1, 32'h3100);
    retire_one(32'h3100, 32'hB002, 1, 0, 32'h3F00);
    retire_one(32'h3104, 32'hB003, 0, 0, 0);
    retire_one(32'h3108, 32'hB004, 1, 1, 32'h3200);
    idle(1);
    do_fetch(32'h3004, 3'b101);
    check("R3", "hit on branch-limited line", 256'(resp_hit), 256'(1));
    check("R3", "count at branch limit", 256'(resp_count), 256'(5));
    check("R5", "next after taken final branch", 256'(resp_next_pc), 256'(32'h3200));
    check("R9", "unused slot zero", 256'(resp_instrs[255:160]), 256'(0));
    do_fetch(32'h3004, 3'b100);
    check("R4", "wrong first direction misses", 256'(resp_hit), 256'(0));
    check("R9", "miss count zero", 256'(resp_count), 256'(0));
    do_fetch(32'h3004, 3'b111);
    check("R4", "wrong second direction misses", 256'(resp_hit), 256'(0));

    // Trace C: 8 instructions ending in a not-taken branch (index 2)
    for (int i = 0; i < 7; i++) retire_one(32'h4008 + 32'(4*i), 32'hC000 + 32'(i), 0, 0, 0);
    retire_one(32'h4024, 32'hC007, 1, 0, 32'h5000);
    idle(1);
    do_fetch(32'h4008, 3'b110);
    check("R4", "unused prediction bits ignored", 256'(resp_hit), 256'(1));
    check("R5", "next after not-taken final branch", 256'(resp_next_pc), 256'(32'h4028));
    do_fetch(32'h4008, 3'b001);
    check("R4", "mismatch on sole branch misses", 256'(resp_hit), 256'(0));

    // Index and tag fields
    do_fetch(32'h1040, 3'b000);
    check("R10", "same index other tag misses", 256'(resp_hit), 256'(0));
    do_fetch(32'h1002, 3'b000);
    check("R10", "low pc bits ignored", 256'(resp_hit), 256'(1));

    // Trace D replaces trace A at index 0
    for (int i = 0; i < 8; i++) retire_one(32'h2000 + 32'(4*i), 32'hD000 + 32'(i), 0, 0, 0);
    idle(1);
    do_fetch(32'h1000, 3'b000);
    check("R8", "evicted start misses", 256'(resp_hit), 256'(0));
    do_fetch(32'h2000, 3'b000);
    check("R8", "new start hits", 256'(resp_hit), 256'(1));
    check("R8", "new line next", 256'(resp_next_pc), 256'(32'h2020));
    do_fetch(32'h3004, 3'b101);
    check("R8", "other index untouched", 256'(resp_hit), 256'(1));

    // Mixed traffic, checked each cycle against the model
    cur_pc = 32'h8000;
    for (int c = 0; c < 3000; c++) begin
      rs = rnd_step(rs);
      ret_valid = (rs[1:0] != 2'b00);
      ret_pc = cur_pc; ret_instr = rnd_step(rs ^ 32'h55);
      ret_is_br = (rs[4:2] < 3'd3); ret_taken = rs[5];
      ret_target = 32'h8000 + {24'h0, rs[11:6], 2'b00};
      if (ret_valid) cur_pc = (ret_is_br && ret_taken) ? ret_target : cur_pc + 4;
      fetch_valid = rs[12];
      begin
        int ix;
        ix = int'(rs[16:13]);
        fetch_pc = m_valid[ix] ? m_start[ix] : 32'h8000 + {24'h0, rs[22:17], 2'b00};
        if (rs[23])
          fetch_pred = {m_flag[ix][2], m_flag[ix][1], m_flag[ix][0]};
        else
          fetch_pred = rs[26:24];
      end
      @(negedge clk);
    end
    ret_valid = 0; fetch_valid = 0;
    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule